// File: doc/BRIEF.md
# Receive Character Queue with Per-Slot Error Status

This block sits between the receiver of a serial controller channel and the processor's data read port. It holds each received character in a small circular queue. Next to each character it keeps a three-bit error record: framing/CRC, overrun and parity. The receiver pushes characters through a write strobe, and the processor pops them through a read strobe. On each pop the character appears on a data output and its error record is copied into a status register.

A pop that finds an error in its slot raises a special-condition interrupt strobe and does not advance the read pointer. The queue stays locked: further reads return the same character and the same error record. This lasts until an error-reset command steps the read pointer past the slot.

A push into a full queue does not advance the write pointer. It overwrites the spare slot, which then holds the newest character, and marks that slot with the overrun flag. A receive interrupt strobe follows each push or only the first push after an arm command, depending on a two-bit mode input. A character-available flag tells the processor when data is waiting.

Top module: `rx_err_queue`

## Requirements
- R1: The queue is full when the write pointer plus one equals the read pointer, or when the write pointer is at slot DEPTH-1 and the read pointer is at 0. So at most DEPTH-1 characters (2 with the default DEPTH of 3) are held and read back in push order.
- R2: A push into a non-full queue stores the character together with its framing and parity flags, clears the overrun flag of that slot, and advances the write pointer, wrapping from DEPTH-1 to 0.
- R3: A push into a full queue writes the character into the slot at the write pointer and sets that slot's overrun flag. It does not advance the write pointer, so the characters already queued are read back unchanged.
- R4: `char_avail` is 1 in the cycle after any push. It returns to 0 in the cycle after a read, or an error reset, leaves the queue empty, unless a push happens in that same cycle.
- R5: With `int_mode` 2'b10 or 2'b11 (all characters), `rx_irq` is 1 for exactly the one cycle after each push.
- R6: With `int_mode` 2'b01 (first character), `rx_irq` pulses only for the first push after a `cpu_arm_next` strobe. Later pushes give no pulse until the next arm. With `int_mode` 2'b00, `rx_irq` stays 0.
- R7: A read from a non-empty queue puts the head character on `rd_char` in the next cycle. It also replaces `rd_status` with that slot's error record, encoded as bit 2 framing/CRC, bit 1 overrun and bit 0 parity.
- R8: If any bit of the record read is set, `spec_irq` is 1 for the next cycle and the read pointer is not advanced. Repeated reads then return the same character and the same record, each with a fresh `spec_irq` pulse.
- R9: `cpu_err_reset` advances the read pointer by one slot when the queue is not empty, which unlocks it. On an empty queue it has no effect.
- R10: A read from an empty queue leaves `rd_char`, `rd_status` and both pointers unchanged.
- R11: A synchronous active-high `rst` clears both pointers, every stored error flag, the status register, `char_avail`, the arm state and both interrupt strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_push | input | 1 | Receiver strobe: push `rx_char` |
| rx_char | input | DW | Received character |
| rx_frame_err | input | 1 | Framing/CRC error of the pushed character |
| rx_par_err | input | 1 | Parity error of the pushed character |
| cpu_read | input | 1 | Processor data read strobe |
| cpu_err_reset | input | 1 | Error-reset command: step past the head slot |
| cpu_arm_next | input | 1 | Arm the interrupt for the next received character |
| int_mode | input | 2 | Receive interrupt mode: 00 off, 01 first, 10/11 all |
| rd_char | output | DW | Last character read |
| rd_status | output | 3 | Error record of the last read: {frame, overrun, parity} |
| char_avail | output | 1 | At least one character waiting |
| rx_irq | output | 1 | Receive interrupt request strobe |
| spec_irq | output | 1 | Special-condition interrupt request strobe |

## Verification
Every output comes from a register, so each result is due exactly one clock after the strobe that causes it. `rd_char`, `rd_status` and `spec_irq` follow a read; `char_avail` and `rx_irq` follow a push; a pointer move shows up on the following read. The bench changes inputs on the falling edge and holds each strobe for one cycle. It checks on the very next falling edge, one rising edge later, so it never samples a value that is still settling. Queue-internal effects such as the held read pointer, the overrun overwrite and a no-op error reset are checked through the characters that later reads return.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // error record kept beside every character
  typedef struct packed {
    logic frame;   // framing / CRC
    logic ovr;     // overrun
    logic par;     // parity
  } rxq_err_t;

  // receive interrupt selection
  typedef enum logic [1:0] {
    RXI_OFF   = 2'b00,
    RXI_FIRST = 2'b01,
    RXI_ALL   = 2'b10,
    RXI_ALL_B = 2'b11
  } rxq_mode_e;

  // circular successor of a slot index
  function automatic int unsigned rxq_next(int unsigned p, int unsigned depth);
    return (p + 1 >= depth) ? 0 : p + 1;
  endfunction

  // full test: one slot is always left unused
  function automatic logic rxq_is_full(int unsigned wp, int unsigned rp,
                                       int unsigned depth);
    return (wp + 1 == rp) || ((wp == depth - 1) && (rp == 0));
  endfunction

  function automatic logic rxq_has_err(rxq_err_t e);
    return e.frame | e.ovr | e.par;
  endfunction

  function automatic logic rxq_mode_all(rxq_mode_e m);
    return (m == RXI_ALL) || (m == RXI_ALL_B);
  endfunction

endpackage

// File: rtl/rxq_ptrs.sv
module rxq_ptrs
  import rxq_pkg::*;
#(
  parameter int DEPTH = 3,
  parameter int PW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv_w,
  input  logic          adv_r,
  output logic [PW-1:0] wp,
  output logic [PW-1:0] rp,
  output logic          full,
  output logic          empty
);

  logic [PW-1:0] wp_nx;
  logic [PW-1:0] rp_nx;

  always_comb begin
    wp_nx = PW'(rxq_next(int'(wp), DEPTH));
    rp_nx = PW'(rxq_next(int'(rp), DEPTH));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (adv_w) wp <= wp_nx;
      if (adv_r) rp <= rp_nx;
    end
  end

  always_comb begin
    full  = rxq_is_full(int'(wp), int'(rp), DEPTH);
    empty = (wp == rp);
  end

endmodule

// File: rtl/rxq_slots.sv
module rxq_slots
  import rxq_pkg::*;
#(
  parameter int DEPTH = 3,
  parameter int DW    = 8,
  parameter int PW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  rxq_err_t      wr_err,
  input  logic [PW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output rxq_err_t      rd_err
);

  logic [DW-1:0] data_q [DEPTH];
  rxq_err_t      err_q  [DEPTH];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic hit;
      assign hit = wr_en && (int'(wr_addr) == g);

      // character storage needs no reset: it is never read before written
      always_ff @(posedge clk) begin
        if (hit) data_q[g] <= wr_data;
      end

      always_ff @(posedge clk) begin
        if (rst)      err_q[g] <= '0;
        else if (hit) err_q[g] <= wr_err;
      end
    end
  endgenerate

  always_comb begin
    rd_data = data_q[rd_addr];
    rd_err  = err_q[rd_addr];
  end

endmodule

// File: rtl/rxq_irq.sv
module rxq_irq
  import rxq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  rxq_mode_e mode,
  input  logic      arm_next,
  input  logic      push_evt,
  input  logic      err_read_evt,
  output logic      rx_irq,
  output logic      spec_irq
);

  logic armed;
  logic fire_rx;

  always_comb begin
    fire_rx = push_evt &&
              (rxq_mode_all(mode) || ((mode == RXI_FIRST) && armed));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
    end else if (arm_next) begin
      armed <= 1'b1;
    end else if (push_evt && (mode == RXI_FIRST)) begin
      armed <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_irq   <= 1'b0;
      spec_irq <= 1'b0;
    end else begin
      rx_irq   <= fire_rx;
      spec_irq <= err_read_evt;
    end
  end

endmodule

// File: rtl/rx_err_queue.sv
module rx_err_queue
  import rxq_pkg::*;
#(
  parameter int DEPTH = 3,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_char,
  input  logic          rx_frame_err,
  input  logic          rx_par_err,
  input  logic          cpu_read,
  input  logic          cpu_err_reset,
  input  logic          cpu_arm_next,
  input  logic [1:0]    int_mode,
  output logic [DW-1:0] rd_char,
  output logic [2:0]    rd_status,
  output logic          char_avail,
  output logic          rx_irq,
  output logic          spec_irq
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  // named internal events
  logic [PW-1:0] wp, rp;
  logic          q_full, q_empty;
  logic [DW-1:0] head_char;
  rxq_err_t      head_err;
  rxq_err_t      push_err;
  logic          read_hit;
  logic          read_err;
  logic          reset_hit;
  logic          adv_w, adv_r;
  logic          drain_empty;

  always_comb begin
    read_hit  = cpu_read && !q_empty;
    read_err  = read_hit && rxq_has_err(head_err);
    reset_hit = cpu_err_reset && !q_empty;
    adv_w     = rx_push && !q_full;
    adv_r     = (read_hit && !read_err) || reset_hit;
    // overrun flag follows the full state at the moment of the push
    push_err.frame = rx_frame_err;
    push_err.ovr   = q_full;
    push_err.par   = rx_par_err;
    drain_empty = adv_r && (PW'(rxq_next(int'(rp), DEPTH)) == wp);
  end

  rxq_ptrs #(.DEPTH(DEPTH), .PW(PW)) u_ptrs (
    .clk   (clk),
    .rst   (rst),
    .adv_w (adv_w),
    .adv_r (adv_r),
    .wp    (wp),
    .rp    (rp),
    .full  (q_full),
    .empty (q_empty)
  );

  rxq_slots #(.DEPTH(DEPTH), .DW(DW), .PW(PW)) u_slots (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (rx_push),
    .wr_addr (wp),
    .wr_data (rx_char),
    .wr_err  (push_err),
    .rd_addr (rp),
    .rd_data (head_char),
    .rd_err  (head_err)
  );

  rxq_irq u_irq (
    .clk          (clk),
    .rst          (rst),
    .mode         (rxq_mode_e'(int_mode)),
    .arm_next     (cpu_arm_next),
    .push_evt     (rx_push),
    .err_read_evt (read_err),
    .rx_irq       (rx_irq),
    .spec_irq     (spec_irq)
  );

  // read port and status register
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_char   <= '0;
      rd_status <= '0;
    end else if (read_hit) begin
      rd_char   <= head_char;
      rd_status <= head_err;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              char_avail <= 1'b0;
    else if (rx_push)     char_avail <= 1'b1;
    else if (drain_empty) char_avail <= 1'b0;
  end

endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
  parameter int DEPTH = 3,
  parameter int DW    = 8,
  parameter int PW    = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          rx_push,
  input logic          cpu_read,
  input logic          cpu_err_reset,
  input logic          q_full,
  input logic          q_empty,
  input logic [PW-1:0] wp,
  input logic [PW-1:0] rp,
  input logic [2:0]    head_err,
  input logic [DW-1:0] rd_char,
  input logic [2:0]    rd_status,
  input logic          char_avail,
  input logic          rx_irq,
  input logic          spec_irq
);

  // R3
  ovr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_push && q_full) |=> (wp == $past(wp)));

  // R2
  push_moves_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_push && !q_full) |=> (wp != $past(wp)));

  // R4
  avail_set_chk: assert property (@(posedge clk) disable iff (rst)
    rx_push |=> char_avail);

  // R8
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_read && !q_empty && (head_err != 3'b000) && !cpu_err_reset)
      |=> ($stable(rp) && spec_irq));

  // R8
  spec_cause_chk: assert property (@(posedge clk) disable iff (rst)
    spec_irq |-> ($past(cpu_read) && ($countones(rd_status) != 0)));

  // R5
  rx_cause_chk: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> $past(rx_push));

  // R10
  empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_read && q_empty) |=> ($stable(rd_char) && $stable(rd_status)
                               && $stable(rp)));

  // R9
  reset_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_err_reset && q_empty && !cpu_read) |=> $stable(rp));

  // R11
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (!rx_irq && !spec_irq && !char_avail && wp == '0 && rp == '0));

endmodule

bind rx_err_queue rxq_chk #(.DEPTH(DEPTH), .DW(DW), .PW(PW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .rx_push       (rx_push),
  .cpu_read      (cpu_read),
  .cpu_err_reset (cpu_err_reset),
  .q_full        (q_full),
  .q_empty       (q_empty),
  .wp            (wp),
  .rp            (rp),
  .head_err      (head_err),
  .rd_char       (rd_char),
  .rd_status     (rd_status),
  .char_avail    (char_avail),
  .rx_irq        (rx_irq),
  .spec_irq      (spec_irq)
);

// File: tb/rx_err_queue_bench.sv
module rx_err_queue_bench;

  logic       clk = 1'b0;
  logic       rst;
  logic       rx_push, rx_frame_err, rx_par_err;
  logic [7:0] rx_char;
  logic       cpu_read, cpu_err_reset, cpu_arm_next;
  logic [1:0] int_mode;
  logic [7:0] rd_char;
  logic [2:0] rd_status;
  logic       char_avail, rx_irq, spec_irq;

  int n_run  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  rx_err_queue u_rx_err_queue (
    .clk (clk), .rst (rst),
    .rx_push (rx_push), .rx_char (rx_char),
    .rx_frame_err (rx_frame_err), .rx_par_err (rx_par_err),
    .cpu_read (cpu_read), .cpu_err_reset (cpu_err_reset),
    .cpu_arm_next (cpu_arm_next), .int_mode (int_mode),
    .rd_char (rd_char), .rd_status (rd_status),
    .char_avail (char_avail), .rx_irq (rx_irq), .spec_irq (spec_irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // every strobe lasts one cycle; outputs are checked one rising edge later
  task automatic push(input logic [7:0] c, input logic fe, input logic pe);
    rx_push = 1'b1; rx_char = c; rx_frame_err = fe; rx_par_err = pe;
    @(negedge clk);
    rx_push = 1'b0; rx_frame_err = 1'b0; rx_par_err = 1'b0;
  endtask

  task automatic rd();
    cpu_read = 1'b1;
    @(negedge clk);
    cpu_read = 1'b0;
  endtask

  task automatic err_rst();
    cpu_err_reset = 1'b1;
    @(negedge clk);
    cpu_err_reset = 1'b0;
  endtask

  task automatic arm();
    cpu_arm_next = 1'b1;
    @(negedge clk);
    cpu_arm_next = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 char_avail", char_avail, 0);
    chk("R11 rx_irq", rx_irq, 0);
    chk("R11 spec_irq", spec_irq, 0);
    chk("R11 rd_status", rd_status, 0);
    chk("R11 rd_char", rd_char, 0);
  endtask

  task automatic t_basic();
    int_mode = 2'b10;
    push(8'hA1, 0, 0);
    chk("R5 irq after push", rx_irq, 1);
    chk("R4 avail set", char_avail, 1);
    push(8'hA2, 0, 0);
    chk("R5 irq second push", rx_irq, 1);
    @(negedge clk);
    chk("R5 irq single cycle", rx_irq, 0);
    rd();
    chk("R7 first char", rd_char, 8'hA1);
    chk("R7 clean status", rd_status, 0);
    chk("R4 avail still", char_avail, 1);
    rd();
    chk("R1 order", rd_char, 8'hA2);
    chk("R4 avail cleared", char_avail, 0);
    rd();
    chk("R10 empty read char", rd_char, 8'hA2);
    chk("R10 empty read status", rd_status, 0);
    int_mode = 2'b11;
    push(8'hA3, 0, 0);
    chk("R5 mode 11 irq", rx_irq, 1);
    rd();
  endtask

  task automatic t_overrun();
    int_mode = 2'b00;
    push(8'h11, 0, 0);
    push(8'h22, 0, 0);
    push(8'h33, 0, 0);   // queue full: overwrite spare slot
    chk("R6 mode off no irq", rx_irq, 0);
    rd();
    chk("R3 keeps first", rd_char, 8'h11);
    rd();
    chk("R1 capacity two", rd_char, 8'h22);
    chk("R3 queue drained", char_avail, 0);
    rd();
    chk("R3 no extra char", rd_char, 8'h22);
    push(8'h44, 0, 0);
    rd();
    chk("R2 char after overrun", rd_char, 8'h44);
    chk("R2 overrun cleared", rd_status, 0);
  endtask

  task automatic t_lock();
    push(8'h55, 1, 0);
    push(8'h66, 0, 0);
    rd();
    chk("R7 frame char", rd_char, 8'h55);
    chk("R7 frame bit2", rd_status, 3'b100);
    chk("R8 spec pulse", spec_irq, 1);
    rd();
    chk("R8 locked repeat", rd_char, 8'h55);
    chk("R8 spec again", spec_irq, 1);
    err_rst();
    chk("R8 spec drops", spec_irq, 0);
    rd();
    chk("R9 unlocked", rd_char, 8'h66);
    chk("R9 clean status", rd_status, 0);
    chk("R9 no spec", spec_irq, 0);
    push(8'h77, 0, 1);
    rd();
    chk("R7 parity bit0", rd_status, 3'b001);
    err_rst();
    chk("R4 reset empties", char_avail, 0);
  endtask

  task automatic t_reset_empty();
    err_rst();           // empty: must not move the read pointer
    push(8'h88, 0, 0);
    rd();
    chk("R9 no effect empty", rd_char, 8'h88);
    chk("R9 status", rd_status, 0);
  endtask

  task automatic t_first();
    int_mode = 2'b01;
    push(8'h01, 0, 0);
    chk("R6 unarmed", rx_irq, 0);
    rd();
    arm();
    push(8'h02, 0, 0);
    chk("R6 armed fires", rx_irq, 1);
    push(8'h03, 0, 0);
    chk("R6 only first", rx_irq, 0);
    rd(); rd();
    int_mode = 2'b00;
    arm();
    push(8'h04, 0, 0);
    chk("R6 mode off armed", rx_irq, 0);
    rd();
  endtask

  initial begin
    rst = 1'b1; rx_push = 0; rx_char = 0; rx_frame_err = 0; rx_par_err = 0;
    cpu_read = 0; cpu_err_reset = 0; cpu_arm_next = 0; int_mode = 2'b10;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_overrun();
    t_lock();
    t_reset_empty();
    t_first();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule